// File: doc/BRIEF.md
# Instruction Decoder and Branch Evaluator

This block turns one 16-bit instruction word into the control signals an 8-bit processor core needs for that instruction. The word is split into four 4-bit fields. The top field is the primary opcode. For opcode 0, the next field picks a control operation: idle, halt, or one of seven jumps. The block reports the class of the instruction and passes the three register-index fields through. It also gives the immediate byte, the arithmetic/logic operation select, and the read, write and memory enables.

The same logic checks the branch condition. It reads the zero and negative bits of the flags byte and raises a jump-taken signal when the decoded jump's condition holds. A jump's target address is not an immediate. It is held in two registers: the field at bits [7:4] names the register with the high byte, and the field at bits [3:0] names the register with the low byte. The control unit owns register reads, address formation and sequencing. This block is purely combinational.

Top module: `idec_top`

## Requirements
- R1: `class_o` gives the instruction class: 0 idle (opcode 0, sub-code 0), 1 halt (opcode 0, sub-code 1), 2 jump (opcode 0, sub-codes 2..8), 3 load (opcode 1), 4 store (opcode 2), 5 load-immediate (opcode 3), 6 ALU (opcodes 4..13), and 7 illegal. Class 7 covers opcode 0 with sub-codes 9..15 and opcodes 14 and 15. `illegal_o` is high exactly for class 7.
- R2: `dst_idx_o`, `mid_idx_o` and `low_idx_o` always equal bits [11:8], [7:4] and [3:0] of the instruction.
- R3: The read enables work as follows. Load and jump read the mid and low fields. Store reads all three fields: top is the address high byte, mid is the address low byte, low is the data source. ALU operations read the mid field (Src2) and the low field (Src1). Idle, halt, load-immediate and illegal read nothing.
- R4: `rf_we_o` is high for load, load-immediate and ALU classes. `mem_rd_o` is high only for load. `mem_wr_o` is high only for store.
- R5: `imm_o` equals instruction bits [7:0] for load-immediate and is 0 for every other class.
- R6: For opcodes 4..13, `alu_op_o` equals opcode minus 4: 0 add, 1 sub, 2 mul, 3 div, 4 shift left, 5 shift right, 6 not, 7 and, 8 xor, 9 or. `flags_we_o` is high. For all other opcodes, `alu_op_o` is 0 and `flags_we_o` is low.
- R7: `halt_o` is high only for opcode 0 with sub-code 1.
- R8: With Z = flags bit 0 and N = flags bit 1, `jump_o` is taken as follows. Sub-code 2 always jumps. Sub-code 3 jumps if Z. Sub-code 4 jumps if not Z. Sub-code 5 jumps if N. Sub-code 6 jumps if not N. Sub-code 7 jumps if N or Z. Sub-code 8 jumps if (not N) or Z.
- R9: `jump_o` is low for every non-jump instruction whatever the flags. Flag bits 2..7 have no effect on any output.
- R10: An illegal instruction raises no read enable, no write enable, no memory enable, no halt and no jump.
- R11: The NOT operation (opcode 10) takes its source from the mid field only. `rd_low_en_o` stays low whatever bits [3:0] hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| flags_i | input | 8 | Flags byte (bit 0 zero, bit 1 negative) |
| class_o | output | 3 | Instruction class code |
| dst_idx_o | output | 4 | Field at bits [11:8] |
| mid_idx_o | output | 4 | Field at bits [7:4] |
| low_idx_o | output | 4 | Field at bits [3:0] |
| imm_o | output | 8 | Immediate byte, 0 unless load-immediate |
| alu_op_o | output | 4 | ALU operation select |
| rd_top_en_o | output | 1 | Read register named by bits [11:8] |
| rd_mid_en_o | output | 1 | Read register named by bits [7:4] |
| rd_low_en_o | output | 1 | Read register named by bits [3:0] |
| rf_we_o | output | 1 | Register file write to dst field |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| flags_we_o | output | 1 | Flags register write |
| halt_o | output | 1 | Halt request |
| jump_o | output | 1 | Jump taken |
| illegal_o | output | 1 | Undefined instruction |

## Verification
The assertions are combinational. They assume both input words are fully known and have settled before they are evaluated. The bench holds each instruction and flags value for a whole clock period and changes them only just after the rising edge. It compares at the falling edge. Stimulus covers every opcode and sub-code pair against all four combinations of the zero and negative bits, with the upper flag bits driven both ways. Random operand fields are added, so the pass-through and don't-care bits are exercised too.

// File: rtl/idec_pkg.sv
package idec_pkg;

  localparam int unsigned OPC_W = 4;

  typedef enum logic [2:0] {
    CLS_IDLE    = 3'd0,
    CLS_HALT    = 3'd1,
    CLS_JUMP    = 3'd2,
    CLS_LOAD    = 3'd3,
    CLS_STORE   = 3'd4,
    CLS_LDIMM   = 3'd5,
    CLS_ALU     = 3'd6,
    CLS_ILLEGAL = 3'd7
  } op_class_e;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0,
    ALU_SUB = 4'd1,
    ALU_MUL = 4'd2,
    ALU_DIV = 4'd3,
    ALU_SHL = 4'd4,
    ALU_SHR = 4'd5,
    ALU_NOT = 4'd6,
    ALU_AND = 4'd7,
    ALU_XOR = 4'd8,
    ALU_OR  = 4'd9
  } alu_op_e;

  localparam logic [OPC_W-1:0] OPC_CTRL      = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LOAD      = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE     = 4'h2;
  localparam logic [OPC_W-1:0] OPC_LDIMM     = 4'h3;
  localparam logic [OPC_W-1:0] OPC_ALU_FIRST = 4'h4;
  localparam logic [OPC_W-1:0] OPC_NOT       = 4'hA;
  localparam logic [OPC_W-1:0] OPC_ALU_LAST  = 4'hD;

  localparam logic [OPC_W-1:0] SUB_IDLE      = 4'h0;
  localparam logic [OPC_W-1:0] SUB_HALT      = 4'h1;
  localparam logic [OPC_W-1:0] SUB_JUMP_LO   = 4'h2;
  localparam logic [OPC_W-1:0] SUB_JUMP_HI   = 4'h8;

  typedef struct packed {
    logic rd_top;
    logic rd_mid;
    logic rd_low;
    logic rf_we;
    logic mem_rd;
    logic mem_wr;
    logic flags_we;
    logic halt;
  } ctrl_t;

endpackage

// File: rtl/idec_class.sv
module idec_class
  import idec_pkg::*;
#(
  parameter int unsigned FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] opc_i,
  input  logic [FIELD_W-1:0] sub_i,
  output op_class_e          cls_o,
  output alu_op_e            alu_op_o
);

  logic is_alu_range;

  always_comb begin
    is_alu_range = (opc_i >= OPC_ALU_FIRST) && (opc_i <= OPC_ALU_LAST);
    cls_o        = CLS_ILLEGAL;
    if (opc_i == OPC_CTRL) begin
      if (sub_i == SUB_IDLE) begin
        cls_o = CLS_IDLE;
      end else if (sub_i == SUB_HALT) begin
        cls_o = CLS_HALT;
      end else if ((sub_i >= SUB_JUMP_LO) && (sub_i <= SUB_JUMP_HI)) begin
        cls_o = CLS_JUMP;
      end else begin
        cls_o = CLS_ILLEGAL;
      end
    end else if (opc_i == OPC_LOAD) begin
      cls_o = CLS_LOAD;
    end else if (opc_i == OPC_STORE) begin
      cls_o = CLS_STORE;
    end else if (opc_i == OPC_LDIMM) begin
      cls_o = CLS_LDIMM;
    end else if (is_alu_range) begin
      cls_o = CLS_ALU;
    end
  end

  always_comb begin
    alu_op_o = ALU_ADD;
    if (is_alu_range) begin
      alu_op_o = alu_op_e'(opc_i - OPC_ALU_FIRST);
    end
  end

endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
(
  input  op_class_e cls_i,
  input  logic      is_not_i,
  output ctrl_t     ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    unique case (cls_i)
      CLS_HALT: begin
        ctrl_o.halt = 1'b1;
      end
      CLS_JUMP: begin
        ctrl_o.rd_mid = 1'b1;
        ctrl_o.rd_low = 1'b1;
      end
      CLS_LOAD: begin
        ctrl_o.rd_mid = 1'b1;
        ctrl_o.rd_low = 1'b1;
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.mem_rd = 1'b1;
      end
      CLS_STORE: begin
        ctrl_o.rd_top = 1'b1;
        ctrl_o.rd_mid = 1'b1;
        ctrl_o.rd_low = 1'b1;
        ctrl_o.mem_wr = 1'b1;
      end
      CLS_LDIMM: begin
        ctrl_o.rf_we = 1'b1;
      end
      CLS_ALU: begin
        ctrl_o.rd_mid   = 1'b1;
        ctrl_o.rd_low   = !is_not_i;
        ctrl_o.rf_we    = 1'b1;
        ctrl_o.flags_we = 1'b1;
      end
      CLS_IDLE, CLS_ILLEGAL: begin
        ctrl_o = '0;
      end
      default: begin
        ctrl_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/idec_branch.sv
module idec_branch #(
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned FLAG_W   = 8,
  parameter int unsigned ZERO_BIT = 0,
  parameter int unsigned NEG_BIT  = 1
) (
  input  logic [FIELD_W-1:0] sub_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic               is_jump_i,
  output logic               taken_o
);

  localparam int unsigned NUM_SUB = 1 << FIELD_W;

  logic               flag_z;
  logic               flag_n;
  logic [NUM_SUB-1:0] cond_vec;
  logic               unused_flag_bits;

  function automatic logic eval_cond(input int unsigned code, input logic z, input logic n);
    logic r;
    case (code)
      2:       r = 1'b1;
      3:       r = z;
      4:       r = !z;
      5:       r = n;
      6:       r = !n;
      7:       r = n | z;
      8:       r = !n | z;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  assign flag_z           = flags_i[ZERO_BIT];
  assign flag_n           = flags_i[NEG_BIT];
  assign unused_flag_bits = ^flags_i;

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_cond
    assign cond_vec[g] = eval_cond(g, flag_z, flag_n);
  end

  assign taken_o = is_jump_i & cond_vec[sub_i];

endmodule

// File: rtl/idec_top.sv
module idec_top
  import idec_pkg::*;
#(
  parameter int unsigned INSTR_W  = 16,
  parameter int unsigned FLAG_W   = 8,
  parameter int unsigned ZERO_BIT = 0,
  parameter int unsigned NEG_BIT  = 1,
  localparam int unsigned FIELD_W = INSTR_W / 4,
  localparam int unsigned IMM_W   = 2 * FIELD_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [FLAG_W-1:0]  flags_i,
  output logic [2:0]         class_o,
  output logic [FIELD_W-1:0] dst_idx_o,
  output logic [FIELD_W-1:0] mid_idx_o,
  output logic [FIELD_W-1:0] low_idx_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic [3:0]         alu_op_o,
  output logic               rd_top_en_o,
  output logic               rd_mid_en_o,
  output logic               rd_low_en_o,
  output logic               rf_we_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               flags_we_o,
  output logic               halt_o,
  output logic               jump_o,
  output logic               illegal_o
);

  logic [FIELD_W-1:0] opc_f;
  logic [FIELD_W-1:0] sub_f;
  op_class_e          cls;
  alu_op_e            alu_op;
  ctrl_t              ctrl;
  logic               is_jump;
  logic               is_not;

  assign opc_f     = instr_i[4*FIELD_W-1:3*FIELD_W];
  assign sub_f     = instr_i[3*FIELD_W-1:2*FIELD_W];
  assign dst_idx_o = sub_f;
  assign mid_idx_o = instr_i[2*FIELD_W-1:FIELD_W];
  assign low_idx_o = instr_i[FIELD_W-1:0];

  idec_class #(.FIELD_W(FIELD_W)) class_i (
    .opc_i    (opc_f),
    .sub_i    (sub_f),
    .cls_o    (cls),
    .alu_op_o (alu_op)
  );

  assign is_not = (opc_f == OPC_NOT);

  idec_ctrl ctrl_i (
    .cls_i    (cls),
    .is_not_i (is_not),
    .ctrl_o   (ctrl)
  );

  assign is_jump = (cls == CLS_JUMP);

  idec_branch #(
    .FIELD_W  (FIELD_W),
    .FLAG_W   (FLAG_W),
    .ZERO_BIT (ZERO_BIT),
    .NEG_BIT  (NEG_BIT)
  ) branch_i (
    .sub_i     (sub_f),
    .flags_i   (flags_i),
    .is_jump_i (is_jump),
    .taken_o   (jump_o)
  );

  assign class_o     = cls;
  assign alu_op_o    = alu_op;
  assign imm_o       = (cls == CLS_LDIMM) ? instr_i[IMM_W-1:0] : '0;
  assign rd_top_en_o = ctrl.rd_top;
  assign rd_mid_en_o = ctrl.rd_mid;
  assign rd_low_en_o = ctrl.rd_low;
  assign rf_we_o     = ctrl.rf_we;
  assign mem_rd_o    = ctrl.mem_rd;
  assign mem_wr_o    = ctrl.mem_wr;
  assign flags_we_o  = ctrl.flags_we;
  assign halt_o      = ctrl.halt;
  assign illegal_o   = (cls == CLS_ILLEGAL);

endmodule

// File: rtl/idec_checks.sv
module idec_checks #(
  parameter int unsigned IMM_W = 8
) (
  input logic [2:0]       class_o,
  input logic [IMM_W-1:0] imm_o,
  input logic [3:0]       alu_op_o,
  input logic             rd_top_en_o,
  input logic             rd_mid_en_o,
  input logic             rd_low_en_o,
  input logic             rf_we_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic             flags_we_o,
  input logic             halt_o,
  input logic             jump_o,
  input logic             illegal_o
);

  always_comb begin
    a_r4_one_side_effect: assert ($onehot0({mem_rd_o, mem_wr_o, halt_o, jump_o}))
      else $error("R4: more than one of memory read/write, halt, jump");
    a_r1_illegal_class: assert (illegal_o == (class_o == 3'd7))
      else $error("R1: illegal flag disagrees with class");
    a_r10_illegal_quiet: assert (!illegal_o || !(rd_top_en_o | rd_mid_en_o | rd_low_en_o |
                                 rf_we_o | mem_rd_o | mem_wr_o | flags_we_o | halt_o | jump_o))
      else $error("R10: illegal instruction raised an enable");
    a_r6_flags_alu: assert (!flags_we_o || ((class_o == 3'd6) && (alu_op_o <= 4'd9)))
      else $error("R6: flags write outside ALU class");
    a_r6_op_zero: assert ((class_o == 3'd6) || (alu_op_o == 4'd0))
      else $error("R6: ALU select nonzero outside ALU class");
    a_r8_jump_class: assert (!jump_o || (class_o == 3'd2))
      else $error("R8: jump taken outside jump class");
    a_r7_halt_class: assert (halt_o == (class_o == 3'd1))
      else $error("R7: halt disagrees with class");
    a_r5_imm_zero: assert ((class_o == 3'd5) || (imm_o == '0))
      else $error("R5: immediate nonzero outside load-immediate");
    a_r4_store_no_write: assert (!mem_wr_o || !rf_we_o)
      else $error("R4: store also writes register file");
  end

endmodule

bind idec_top idec_checks #(.IMM_W(IMM_W)) checks_i (
  .class_o     (class_o),
  .imm_o       (imm_o),
  .alu_op_o    (alu_op_o),
  .rd_top_en_o (rd_top_en_o),
  .rd_mid_en_o (rd_mid_en_o),
  .rd_low_en_o (rd_low_en_o),
  .rf_we_o     (rf_we_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .flags_we_o  (flags_we_o),
  .halt_o      (halt_o),
  .jump_o      (jump_o),
  .illegal_o   (illegal_o)
);

// File: tb/idec_top_tb_top.sv
module idec_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] instr;
  logic [7:0]  flags;

  logic [2:0]  class_o;
  logic [3:0]  dst_idx_o, mid_idx_o, low_idx_o;
  logic [7:0]  imm_o;
  logic [3:0]  alu_op_o;
  logic        rd_top_en_o, rd_mid_en_o, rd_low_en_o;
  logic        rf_we_o, mem_rd_o, mem_wr_o, flags_we_o;
  logic        halt_o, jump_o, illegal_o;

  int checks;
  int errors;
  bit done;

  idec_top dut_i (
    .instr_i     (instr),
    .flags_i     (flags),
    .class_o     (class_o),
    .dst_idx_o   (dst_idx_o),
    .mid_idx_o   (mid_idx_o),
    .low_idx_o   (low_idx_o),
    .imm_o       (imm_o),
    .alu_op_o    (alu_op_o),
    .rd_top_en_o (rd_top_en_o),
    .rd_mid_en_o (rd_mid_en_o),
    .rd_low_en_o (rd_low_en_o),
    .rf_we_o     (rf_we_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .flags_we_o  (flags_we_o),
    .halt_o      (halt_o),
    .jump_o      (jump_o),
    .illegal_o   (illegal_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected values from the reference model
  int e_cls, e_imm, e_alu, e_top, e_mid, e_low, e_we, e_mrd, e_mwr, e_fwe, e_halt, e_jmp, e_ill;

  task automatic model(input logic [15:0] ins, input logic [7:0] fl);
    int opc;
    int sub;
    bit z;
    bit n;
    opc = ins[15:12];
    sub = ins[11:8];
    z = fl[0];
    n = fl[1];
    e_cls = 7; e_imm = 0; e_alu = 0; e_top = 0; e_mid = 0; e_low = 0;
    e_we = 0; e_mrd = 0; e_mwr = 0; e_fwe = 0; e_halt = 0; e_jmp = 0; e_ill = 0;
    if (opc == 0) begin
      if (sub == 0) e_cls = 0;
      else if (sub == 1) begin e_cls = 1; e_halt = 1; end
      else if (sub <= 8) begin
        e_cls = 2; e_mid = 1; e_low = 1;
        case (sub)
          2: e_jmp = 1;
          3: e_jmp = z;
          4: e_jmp = !z;
          5: e_jmp = n;
          6: e_jmp = !n;
          7: e_jmp = n || z;
          default: e_jmp = !n || z;
        endcase
      end else begin e_cls = 7; e_ill = 1; end
    end else if (opc == 1) begin
      e_cls = 3; e_mid = 1; e_low = 1; e_we = 1; e_mrd = 1;
    end else if (opc == 2) begin
      e_cls = 4; e_top = 1; e_mid = 1; e_low = 1; e_mwr = 1;
    end else if (opc == 3) begin
      e_cls = 5; e_we = 1; e_imm = ins[7:0];
    end else if (opc <= 13) begin
      e_cls = 6; e_we = 1; e_fwe = 1; e_alu = opc - 4; e_mid = 1;
      e_low = (opc == 10) ? 0 : 1;
    end else begin
      e_cls = 7; e_ill = 1;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s instr=%h flags=%h actual=%0d expected=%0d",
               req, what, instr, flags, act, exp);
    end
  endtask

  task automatic compare_all();
    model(instr, flags);
    chk((e_cls == 7) ? "R1" : "R1", "class", class_o, e_cls);
    chk("R1", "illegal", illegal_o, e_ill);
    chk("R2", "dst_idx", dst_idx_o, instr[11:8]);
    chk("R2", "mid_idx", mid_idx_o, instr[7:4]);
    chk("R2", "low_idx", low_idx_o, instr[3:0]);
    chk("R3", "rd_top", rd_top_en_o, e_top);
    chk("R3", "rd_mid", rd_mid_en_o, e_mid);
    chk((instr[15:12] == 4'hA) ? "R11" : "R3", "rd_low", rd_low_en_o, e_low);
    chk("R4", "rf_we", rf_we_o, e_we);
    chk("R4", "mem_rd", mem_rd_o, e_mrd);
    chk("R4", "mem_wr", mem_wr_o, e_mwr);
    chk("R5", "imm", imm_o, e_imm);
    chk("R6", "alu_op", alu_op_o, e_alu);
    chk("R6", "flags_we", flags_we_o, e_fwe);
    chk("R7", "halt", halt_o, e_halt);
    chk((e_cls == 2) ? "R8" : "R9", "jump", jump_o, e_jmp);
    if (e_ill != 0)
      chk("R10", "illegal_enables",
          int'({rd_top_en_o, rd_mid_en_o, rd_low_en_o, rf_we_o, mem_rd_o, mem_wr_o,
                flags_we_o, halt_o, jump_o}), 0);
  endtask

  task automatic apply(input logic [15:0] ins, input logic [7:0] fl);
    @(posedge clk);
    #2;
    instr = ins;
    flags = fl;
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    instr  = 16'h0000;
    flags  = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: idle instruction, everything low (R1, R3, R4, R7, R9)
    compare_all();
    @(posedge clk);
    #2 rst_n = 1'b1;

    // directed: jump conditions (R8) with each flag pair
    for (int s = 2; s <= 8; s++) begin
      for (int f = 0; f < 4; f++) begin
        apply({4'h0, 4'(s), 8'h5A}, 8'(f));
        apply({4'h0, 4'(s), 8'hA5}, 8'(f) | 8'hFC);
      end
    end
    // R7 halt, R5 immediate, R11 NOT with nonzero low field
    apply(16'h0100, 8'hFF);
    apply(16'h37C3, 8'h00);
    apply(16'h3F00, 8'h01);
    apply(16'hA24F, 8'h03);
    apply(16'hA240, 8'h00);
    // R10 illegal forms, R9 with all flags set
    apply(16'h09FF, 8'hFF);
    apply(16'h0F00, 8'h01);
    apply(16'hE123, 8'h02);
    apply(16'hFFFF, 8'hFF);
    // R4 store/load
    apply(16'h2ABC, 8'h00);
    apply(16'h1DEF, 8'h01);

    // sweep every opcode/sub-code pair with random operands and flags
    for (int hb = 0; hb < 256; hb++) begin
      for (int f = 0; f < 4; f++) begin
        apply({8'(hb), 8'($urandom)}, {6'($urandom), 2'(f)});
      end
    end
    for (int k = 0; k < 1500; k++) begin
      apply(16'($urandom), 8'($urandom));
    end
    finish_run();
  end

endmodule